// File: doc/BRIEF.md
# Main Clock Stop Monitor

This block watches an external main oscillator clock from the domain of a free-running internal oscillator clock. It asks for a system reset when the main clock stops while monitoring is active. The main clock input is brought into the internal clock domain through a two-flop synchronizer. Rising edges are detected there, and a stop is declared when four internal clock cycles in a row pass with no main-clock edge.

Software starts monitoring by setting an enable bit, which then stays set until reset. While the chip is in STOP mode the main oscillator is halted, so the monitor stands down. When STOP ends, the monitor waits for a programmable settling time, counted in main-clock cycles, before it watches again. If the enable bit was set before STOP, monitoring resumes on its own with no software action. A detected stop gives a one-cycle reset request and sets a sticky flag. The flag can be read back until the next reset.

Top module: `clk_stop_monitor`

## Requirements
- R1: After reset, mon_state is 0 (stopped), register address 0 reads 0x00, register address 1 reads 0x05, and reset_req is 0.
- R2: A write with bit 0 set to address 0, with stop_mode low, moves mon_state to 2 (monitoring) within two clock cycles.
- R3: Once the enable (address 0, bit 0) is set, a write of 0 to it leaves it set. Only reset clears it.
- R4: While stop_mode is high, mon_state is 0 from the next cycle on and no reset request is raised.
- R5: When stop_mode falls with the enable set, mon_state becomes 1 (waiting) for the settling time, then returns to 2 with no register write.
- R6: When stop_mode falls with the enable clear, mon_state stays 0.
- R7: Address 1 holds an 8-bit settling select that reads back as written. Values 1, 2, 3, 4 and 5 select 2^12, 2^13, 2^14, 2^15 and 2^16 main-clock cycles. Any other value selects 2^16.
- R8: In state 2, four consecutive internal cycles with no synchronized main-clock rising edge raise reset_req. A rising edge at least every fourth cycle raises none.
- R9: reset_req is high for exactly one cycle per detection.
- R10: A detection sets a sticky flag, read at address 0 bit 7. Only reset clears it.
- R11: mon_state never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x1_clk | input | 1 | Main oscillator clock being watched, asynchronous |
| stop_mode | input | 1 | High while the chip is in STOP mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode/status, 1 settling select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| reset_req | output | 1 | One-cycle reset request on a detected stop |
| mon_state | output | 2 | 0 stopped, 1 waiting for settling, 2 monitoring |

## Verification
The assertions check four things on every cycle: STOP forces the stopped state, a request only ever follows a cycle spent monitoring, requests are single cycles, and the enable and sticky flag never fall. They also check that the unused state code never appears. Only the bench's scenarios can show the rest. That covers the length of the settling window for each select code and the fallback for invalid codes. It also covers whether a slow or halted main clock trips the detector, whether a clock at the edge of the limit does not, and the resume after STOP with and without the enable.

// File: rtl/cmon_pkg.sv
package cmon_pkg;
  typedef enum logic [1:0] {
    MS_OFF  = 2'd0,
    MS_WAIT = 2'd1,
    MS_MON  = 2'd2
  } mon_state_e;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_STAB = 1'b1;
  localparam logic [7:0] STAB_RESET = 8'h05;
endpackage

// File: rtl/cmon_x1_edge.sv
module cmon_x1_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x1_async,
  output logic x1_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= x1_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign x1_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/cmon_regs.sv
module cmon_regs
  import cmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       det_set,
  output logic       en,
  output logic       flag,
  output logic [7:0] stab_sel,
  output logic [7:0] rdata
);
  logic       en_d, flag_d;
  logic [7:0] sel_d;
  logic       en_ce, sel_ce;

  assign en_ce  = we && (addr == ADDR_MODE) && wdata[0];
  assign sel_ce = we && (addr == ADDR_STAB);

  always_comb begin
    en_d   = en;
    flag_d = flag;
    sel_d  = stab_sel;
    if (en_ce)   en_d   = 1'b1;
    if (det_set) flag_d = 1'b1;
    if (sel_ce)  sel_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      flag     <= 1'b0;
      stab_sel <= STAB_RESET;
    end else begin
      en       <= en_d;
      flag     <= flag_d;
      stab_sel <= sel_d;
    end
  end

  always_comb begin
    if (addr == ADDR_MODE) rdata = {flag, 6'b0, en};
    else                   rdata = stab_sel;
  end
endmodule

// File: rtl/cmon_stab.sv
module cmon_stab #(
  parameter int MIN_EXP = 12,
  parameter int SEL_N   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       x1_rise,
  input  logic [7:0] sel,
  output logic       done
);
  localparam int CNT_W = MIN_EXP + SEL_N;
  localparam int IDX_W = (SEL_N > 1) ? $clog2(SEL_N) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic [IDX_W-1:0] idx;

  always_comb begin
    if (sel >= 8'd1 && sel <= 8'(SEL_N)) idx = IDX_W'(sel - 8'd1);
    else                                 idx = IDX_W'(SEL_N - 1);
    last = (CNT_W'(1) << (MIN_EXP + int'(idx))) - CNT_W'(1);
  end

  assign done = active && x1_rise && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (!active)      cnt_d = '0;
    else if (x1_rise) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cmon_timeout.sv
module cmon_timeout #(
  parameter int TIMEOUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic x1_rise,
  output logic req
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          fire, req_d;

  assign fire = active && !x1_rise && (cnt_q == TW'(TIMEOUT - 1));

  always_comb begin
    cnt_d = cnt_q + TW'(1);
    if (!active || x1_rise || fire) cnt_d = '0;
    req_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req   <= req_d;
    end
  end
endmodule

// File: rtl/clk_stop_monitor.sv
module clk_stop_monitor
  import cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 4,
  parameter int MIN_EXP     = 12,
  parameter int SEL_N       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       x1_clk,
  input  logic       stop_mode,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reset_req,
  output logic [1:0] mon_state
);
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  logic       x1_rise;
  logic       mon_en, det_flag;
  logic [7:0] stab_sel;
  logic       stab_done;
  logic       stop_q;
  logic       stop_release;
  mon_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  cmon_x1_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_i_n), .x1_async(x1_clk), .x1_rise(x1_rise)
  );

  cmon_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .det_set(reset_req), .en(mon_en), .flag(det_flag),
    .stab_sel(stab_sel), .rdata(reg_rdata)
  );

  cmon_stab #(.MIN_EXP(MIN_EXP), .SEL_N(SEL_N)) u_stab (
    .clk(clk), .rst_n(rst_i_n), .active(state_q == MS_WAIT),
    .x1_rise(x1_rise), .sel(stab_sel), .done(stab_done)
  );

  cmon_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
    .clk(clk), .rst_n(rst_i_n), .active(state_q == MS_MON),
    .x1_rise(x1_rise), .req(reset_req)
  );

  assign stop_release = stop_q && !stop_mode;

  always_comb begin
    state_d = state_q;
    if (stop_mode) begin
      state_d = MS_OFF;
    end else begin
      case (state_q)
        MS_OFF: begin
          if (mon_en && stop_release) state_d = MS_WAIT;
          else if (mon_en)            state_d = MS_MON;
        end
        MS_WAIT: if (stab_done) state_d = MS_MON;
        MS_MON:  state_d = MS_MON;
        default: state_d = MS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= MS_OFF;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_mode;
    end
  end

  assign mon_state = state_q;
endmodule

module clk_stop_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_mode,
  input logic [1:0] mon_state,
  input logic       reset_req,
  input logic       mon_en,
  input logic       det_flag
);
  // R4
  stop_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> (mon_state == 2'd0));
  // R4
  req_after_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(mon_state) == 2'd2));
  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(mon_en));
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(det_flag));
  // R11
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_state != 2'd3);
endmodule

bind clk_stop_monitor clk_stop_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .stop_mode(stop_mode), .mon_state(mon_state),
  .reset_req(reset_req), .mon_en(mon_en), .det_flag(det_flag)
);

// File: tb/sim_clk_stop_monitor.sv
module sim_clk_stop_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, x1_clk, stop_mode, reg_we, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reset_req;
  logic [1:0] mon_state;

  int errors = 0, checks = 0;
  int req_cnt = 0;
  int x1_half = 2;
  bit x1_run = 0;
  bit finished = 0;
  logic req_prev = 1'b0;

  clk_stop_monitor u0 (
    .clk(clk), .rst_n(rst_n), .x1_clk(x1_clk), .stop_mode(stop_mode),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reset_req(reset_req), .mon_state(mon_state)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // main clock generator, stepped on falling edges
  initial begin
    int ph;
    x1_clk = 1'b0;
    ph = 0;
    forever begin
      @(negedge clk);
      if (x1_run) begin
        ph++;
        if (ph >= x1_half) begin
          x1_clk = ~x1_clk;
          ph = 0;
        end
      end
    end
  end

  // request pulse counter and width check (R9)
  always @(negedge clk) begin
    if (reset_req) req_cnt++;
    if (reset_req && req_prev) begin
      errors++;
      $display("FAIL R9: reset_req wide, actual=2+ cycles expected=1");
    end
    req_prev = reset_req;
  end

  function automatic int exp_cycles(input logic [7:0] v);
    if (v >= 8'd1 && v <= 8'd5) return 1 << (11 + int'(v));
    return 1 << 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // STOP entry, release, and timing of the settling window
  task automatic stop_cycle(input logic [7:0] sel, input int half);
    int n, bq, tol, expn;
    bq = req_cnt;
    wr(1'b1, sel);
    @(negedge clk);
    stop_mode = 1'b1;
    x1_run = 0;
    repeat (20) @(negedge clk);
    check("R4 state in STOP", int'(mon_state), 0);
    check("R4 no request in STOP", req_cnt - bq, 0);
    x1_half = half;
    x1_run = 1;
    stop_mode = 1'b0;
    @(negedge clk);
    check("R5 waiting after release", int'(mon_state), 1);
    n = 1;
    while (mon_state == 2'd1 && n < 150000) begin
      @(negedge clk);
      n++;
    end
    expn = exp_cycles(sel) * 2 * half;
    tol = 4 * half + 6;
    checks++;
    if (n < expn - tol || n > expn + tol) begin
      errors++;
      $display("FAIL R7: settling cycles actual=%0d expected=%0d", n, expn);
    end
    check("R5 resumes monitoring", int'(mon_state), 2);
    check("R5 no request in window", req_cnt - bq, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] d, v;
    int base;
    void'($urandom(32'd4711));
    rst_n = 1'b0; stop_mode = 1'b0; reg_we = 1'b0; reg_addr = 1'b0;
    reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    check("R1 state", int'(mon_state), 0);
    rd(1'b0, d); check("R1 mode reg", int'(d), 8'h00);
    rd(1'b1, d); check("R1 stab reg", int'(d), 8'h05);
    check("R1 request", int'(reset_req), 0);

    // R7 random readback of the select register
    for (int i = 0; i < 12; i++) begin
      v = 8'($urandom);
      wr(1'b1, v);
      rd(1'b1, d);
      check("R7 readback", int'(d), int'(v));
    end

    // R2 enable
    x1_half = 2; x1_run = 1;
    repeat (10) @(negedge clk);
    base = req_cnt;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h01;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    check("R2 monitoring within two cycles", int'(mon_state), 2);

    // R3 clearing write ignored
    wr(1'b0, 8'h00);
    rd(1'b0, d); check("R3 enable kept", int'(d[0]), 1);

    // R8 edge every fourth cycle: no request
    repeat (200) @(negedge clk);
    check("R8 no request at limit", req_cnt - base, 0);

    // R5 / R7 STOP cycles: valid code, then a random invalid one
    stop_cycle(8'h01, 2);
    v = ($urandom % 2 == 0) ? 8'h00 : 8'(8'h06 + ($urandom % 200));
    stop_cycle(v, 1);

    // R8 / R10 halted main clock
    x1_half = 2;
    repeat (20) @(negedge clk);
    base = req_cnt;
    rd(1'b0, d); check("R10 flag clear before stop", int'(d[7]), 0);
    x1_run = 0;
    repeat (12) @(negedge clk);
    checks++;
    if (req_cnt - base < 1) begin
      errors++;
      $display("FAIL R8: halted clock requests actual=%0d expected>=1", req_cnt - base);
    end
    x1_run = 1;
    repeat (20) @(negedge clk);
    rd(1'b0, d); check("R10 flag set", int'(d[7]), 1);

    // R8 slow clock, gap of five cycles: requests
    x1_half = 3;
    repeat (20) @(negedge clk);
    base = req_cnt;
    repeat (60) @(negedge clk);
    checks++;
    if (req_cnt - base < 1) begin
      errors++;
      $display("FAIL R8: slow clock requests actual=%0d expected>=1", req_cnt - base);
    end
    x1_half = 2;
    repeat (20) @(negedge clk);
    base = req_cnt;
    repeat (60) @(negedge clk);
    check("R8 no request back at limit", req_cnt - base, 0);
    rd(1'b0, d); check("R10 flag still set", int'(d[7]), 1);

    // R10 / R3 reset clears, R6 release without enable
    do_reset();
    rd(1'b0, d); check("R10 flag cleared by reset", int'(d), 8'h00);
    stop_mode = 1'b1;
    repeat (10) @(negedge clk);
    stop_mode = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 stays stopped", int'(mon_state), 0);
    check("R11 valid state code", int'(mon_state != 2'd3), 1);

    summary();
  end
endmodule